// File: doc/BRIEF.md
# Sequential Booth Shift-Add Multiplier

This block multiplies two 32-bit operands over many clock cycles and returns a 64-bit product. It keeps the datapath small: one 33-bit add/subtract unit, a 32-bit multiplicand register and a single 64-bit product register.

The second operand is loaded into the low half of the product register, so no separate multiplier register exists. Each step retires one bit of that operand from the bottom of the register as the whole register shifts right. A mode input chosen at start selects one of two ways of multiplying:
- plain unsigned shift-add;
- radix-2 Booth recoding for two's-complement signed operands.

A caller pulses `start` with the operands and the mode while the block is idle. It then waits for the one-cycle `done` pulse, after which the high and low halves of the product can be read.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset `done` is 0 and `resultHi`/`resultLo` are all zero.
- R2: With `signedMode`=0 at start, `{resultHi,resultLo}` equals the unsigned 64-bit product of `opA` and `opB` when `done` is 1.
- R3: With `signedMode`=1 at start, `{resultHi,resultLo}` equals the two's-complement 64-bit product of `opA` and `opB` when `done` is 1. This includes zero operands and the most negative value 0x80000000 on either or both inputs.
- R4: `done` is 1 for exactly one cycle. It rises in the cycle that follows the 32nd rising clock edge after the edge that accepted `start`.
- R5: A `start` that arrives while an operation is in progress is ignored; the running product and its timing are unchanged.
- R6: After `done` the result outputs hold their value until the next accepted `start`.
- R7: During each iteration the multiplicand register is unchanged, and the low half of the product register shifts right by one bit.
- R8: In Booth mode a history bit is cleared when an operation starts. After each step it equals the product bit 0 that the step examined. A bit pair {bit0, history} of 10 subtracts the multiplicand, 01 adds it, and 00 or 11 leaves the high half unchanged before the shift.
- R9: Changing `signedMode`, `opA` or `opB` after start has no effect on the running operation.
- R10: A `start` given in the same cycle that `done` is 1 is accepted. The next product then follows with the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; taken only when idle |
| opA | input | 32 | Multiplicand |
| opB | input | 32 | Multiplier |
| signedMode | input | 1 | 1 = Booth signed, 0 = unsigned shift-add |
| resultHi | output | 32 | Upper half of the product |
| resultLo | output | 32 | Lower half of the product |
| done | output | 1 | One-cycle pulse when the product is ready |

## Verification
The assertions check the per-cycle rules on every cycle:
- the multiplicand stays fixed;
- the low half of the product register shifts right by one bit;
- the Booth history bit clears at start and then tracks product bit 0;
- the mode stays latched;
- the step counter keeps advancing while busy;
- `done` never lasts two cycles.

Only the bench scenarios show that the final product is arithmetically correct. They cover:
- random operands in both modes;
- zero operands;
- the most negative operand on either or both sides;
- starts and operand or mode changes injected mid-operation;
- starts given back-to-back in the `done` cycle;
- results held over idle gaps.

// File: rtl/booth_mult_pkg.sv
package booth_mult_pkg;
  typedef struct packed {
    logic load;  // capture operands, clear product high half and history bit
    logic step;  // one add/sub-then-shift iteration
  } dpCtl_t;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } ctlState_t;
endpackage

// File: rtl/booth_mult_dp.sv
module booth_mult_dp
  import booth_mult_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpCtl_t         ctl,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  input  logic           signedIn,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [W-1:0]  mcand;
  logic          prevBit;
  logic          signedReg;
  logic [W-1:0]  hiHalf;
  logic          hiExt;
  logic          mExt;
  logic          addEn;
  logic          subEn;
  logic [W:0]    sum;
  logic [PW-1:0] prodNext;

  assign hiHalf = prod[PW-1:W];
  assign hiExt  = signedReg & hiHalf[W-1];
  assign mExt   = signedReg & mcand[W-1];

  always_comb begin
    if (signedReg) begin
      subEn = prod[0] & ~prevBit;
      addEn = ~prod[0] & prevBit;
    end else begin
      subEn = 1'b0;
      addEn = prod[0];
    end
    if (subEn)      sum = {hiExt, hiHalf} - {mExt, mcand};
    else if (addEn) sum = {hiExt, hiHalf} + {mExt, mcand};
    else            sum = {hiExt, hiHalf};
    prodNext = {sum, prod[W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand     <= '0;
      prod      <= '0;
      prevBit   <= 1'b0;
      signedReg <= 1'b0;
    end else if (ctl.load) begin
      mcand     <= opA;
      prod      <= {{W{1'b0}}, opB};
      prevBit   <= 1'b0;
      signedReg <= signedIn;
    end else if (ctl.step) begin
      prod      <= prodNext;
      prevBit   <= prod[0];
    end
  end

  // R7: multiplicand never moves during an iteration
  a_r7_mcand_hold: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> $stable(mcand));
  // R7: low half shifts right by one each step
  a_r7_low_shift: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> prod[W-2:0] == $past(prod[W-1:1]));
  // R8: history bit cleared at start
  a_r8_prev_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> !prevBit);
  // R8: history bit follows the examined bit 0
  a_r8_prev_track: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> prevBit == $past(prod[0]));
  // R9: mode latched for the whole operation
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> $stable(signedReg));
endmodule

// File: rtl/booth_mult_ctl.sv
module booth_mult_ctl
  import booth_mult_pkg::*;
#(
  parameter int W = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  output dpCtl_t ctl,
  output logic   done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  ctlState_t     state;
  logic [CW-1:0] cnt;

  always_comb begin
    ctl.load = (state == S_IDLE) && start;
    ctl.step = (state == S_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state <= S_RUN;
            cnt   <= '0;
          end
        end
        S_RUN: begin
          cnt <= cnt + CW'(1);
          if (cnt == LAST) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4: done is a single-cycle pulse
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R4: done follows an iteration step
  a_r4_done_after_step: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(ctl.step));
  // R5: once running, the counter keeps advancing whatever start does
  a_r5_run_advances: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && cnt != LAST) |=> (state == S_RUN && cnt == $past(cnt) + CW'(1)));
  // R5: no operand load while busy
  a_r5_no_load_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN) |-> !ctl.load);
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_mult_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         signedMode,
  output logic [W-1:0] resultHi,
  output logic [W-1:0] resultLo,
  output logic         done
);
  dpCtl_t         ctl;
  logic [2*W-1:0] prod;

  booth_mult_ctl #(.W(W)) u_ctl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl),
    .done  (done)
  );

  booth_mult_dp #(.W(W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .opA      (opA),
    .opB      (opB),
    .signedIn (signedMode),
    .prod     (prod)
  );

  assign resultHi = prod[2*W-1:W];
  assign resultLo = prod[W-1:0];

  // R6: result holds while idle with no done
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> ({resultHi, resultLo} == $past({resultHi, resultLo})));
endmodule

// File: tb/booth_seq_mult_bench.sv
module booth_seq_mult_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        signedMode = 1'b0;
  logic [31:0] resultHi;
  logic [31:0] resultLo;
  logic        done;

  int checks = 0;
  int fails = 0;
  logic [63:0] expQ[$];
  string       tagQ[$];
  logic        prevDone = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  booth_seq_mult u_booth_seq_mult (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .signedMode(signedMode), .resultHi(resultHi), .resultLo(resultLo), .done(done)
  );

  function automatic logic [63:0] refProd(input logic [31:0] a, input logic [31:0] b, input logic s);
    logic [63:0] ea, eb;
    ea = s ? {{32{a[31]}}, a} : {32'b0, a};
    eb = s ? {{32{b[31]}}, b} : {32'b0, b};
    return ea * eb;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each done pulse; R4 single pulse
  always @(negedge clk) begin
    if (rstN) begin
      if (done && prevDone) check("R4 pulse width", 64'd1, 64'd0);
      if (done) begin
        if (expQ.size() == 0) check("R4 unexpected done", 64'd1, 64'd0);
        else begin
          string t;
          logic [63:0] e;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, {resultHi, resultLo}, e);
        end
      end
      prevDone <= done;
    end
  end

  // Driver: called at a negedge while idle; returns at the negedge where done is 1.
  // disturb: mid-run start with other operands and flipped mode (R5, R9).
  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input logic s,
                       input string tag, input bit disturb);
    opA = a; opB = b; signedMode = s; start = 1'b1;
    expQ.push_back(refProd(a, b, s));
    tagQ.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= 31; i++) begin
      @(negedge clk);
      if (disturb && (i == 5 || i == 20)) begin
        start = 1'b1; opA = ~a; opB = b ^ 32'h5a5a_1234; signedMode = ~s;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check("R4 no early done", {63'b0, done}, 64'd0);
    @(negedge clk);
    check("R4 done latency", {63'b0, done}, 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset result", {resultHi, resultLo}, 64'd0);
    check("R1 reset done", {63'b0, done}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    runOp(32'd7, 32'd9, 1'b0, "R2 small unsigned", 0);
    @(negedge clk);
    runOp(32'hffff_ffff, 32'hffff_ffff, 1'b0, "R2 max unsigned", 0);
    @(negedge clk);
    runOp(32'h0, 32'hdead_beef, 1'b0, "R2 zero unsigned", 0);
    @(negedge clk);
    runOp(32'hffff_fffd, 32'd2, 1'b1, "R3 neg times pos", 0);
    @(negedge clk);
    runOp(32'h8000_0000, 32'h8000_0000, 1'b1, "R3 both most negative", 0);
    @(negedge clk);
    runOp(32'h8000_0000, 32'd1, 1'b1, "R3 most negative times one", 0);
    @(negedge clk);
    runOp(32'h7fff_ffff, 32'h8000_0000, 1'b1, "R3 max pos times most neg", 0);
    @(negedge clk);
    runOp(32'h0, 32'h8000_0000, 1'b1, "R3 zero times most neg", 0);
    @(negedge clk);
    runOp(32'h8000_0000, 32'hffff_ffff, 1'b0, "R2 unsigned high bit", 0);
    @(negedge clk);

    // R5 / R9: disturbed runs in both modes
    runOp(32'h1234_5678, 32'h9abc_def0, 1'b0, "R5 R9 disturbed unsigned", 1);
    @(negedge clk);
    runOp(32'hfedc_ba98, 32'h0765_4321, 1'b1, "R5 R9 disturbed signed", 1);

    // R6: hold after done across idle cycles with changing inputs
    held = {resultHi, resultLo};
    opA = 32'h1111_1111; opB = 32'h2222_2222; signedMode = 1'b0;
    repeat (10) @(negedge clk);
    check("R6 result held", {resultHi, resultLo}, held);

    // R10: back-to-back starts in the done cycle, random operands
    for (int k = 0; k < 40; k++) begin
      runOp($urandom, $urandom, k[0], k[0] ? "R10 R3 random signed" : "R10 R2 random unsigned", 0);
    end
    @(negedge clk);
    repeat (3) @(negedge clk);
    check("R4 queue drained", 64'(expQ.size()), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule